// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a two-way set-associative data cache that sits between the memory stage of a pipeline and a slower backing memory. The pipeline presents one load or store at a time and holds it steady. A hit finishes in the cycle it is presented, with no stall. A miss raises `stall`, and `stall` stays high until the line is resident. If the victim line holds modified data, it is first written back in full, then the new line is read.

Stores use write-back and write-allocate. A store hit only updates the resident line and marks it modified. A store miss first brings the whole line in from memory. The sequencer then returns to idle, the held store now hits, and its bytes are merged into the line. Every memory transfer is split-phase: the cache issues a request for one cycle and then polls for a done indication before it moves on.

Top module: `wb2way_cache`

## Requirements
- R1: Reset clears every valid, modified and recency bit. After reset `stall` and `mem_req` are low, and the first access to any address misses and reads memory.
- R2: The byte address splits into a 3-bit offset in bits [2:0], which is ignored, an index in the next log2(SETS) bits, and a tag in the bits above. A load returns the whole 64-bit line.
- R3: A hit in either way completes with `stall` low in the same cycle and no memory request. The load data comes from the matching way.
- R4: A store writes byte i of `req_wdata` (bits [8i+7:8i]) only when `req_be[i]` is 1. A store hit marks the line modified and causes no memory write.
- R5: On a miss the victim is an invalid way if there is one (way 0 before way 1). Otherwise it is the least recently used way. Every hit and every fill marks the touched way as most recent in its set.
- R6: A valid, modified victim is written back before the read is issued. The write-back is one write of the full line to address {victim tag, index, 3'b000}, carrying the data the line holds.
- R7: A clean or invalid victim produces no write, only a single line read.
- R8: A store miss reads the line from memory and installs it unmodified. It then completes as a hit that merges the store bytes and marks the line modified. The store data itself is never written to memory directly.
- R9: Each memory request is a single-cycle `mem_req` pulse with `mem_we`, `mem_addr` and `mem_wdata` valid. No new request is issued until `mem_done` for the previous one.
- R10: `stall` is high from the cycle a miss is seen until the fill completes. This includes every cycle of the write-back and of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access presented, held until `stall` is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| rsp_rdata | output | 64 | Load data, valid when `stall` is low |
| stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 64 | Write-back line data |
| mem_done | input | 1 | Outstanding request finished |
| mem_rdata | input | 64 | Read line, valid with `mem_done` |

## Verification
The hardest case to reach is a miss in a set whose two ways are both valid and both modified. In that case the recency bit alone picks the victim, and the write-back must carry bytes that were merged by earlier partial stores. The stimulus fills every set of a four-set build with two tags and then dirties both ways with partial byte masks. It re-touches one way and then brings in a third tag. The bench then long-runs a pseudo-random mix of loads and stores over six tags per set. Memory latency varies from request to request. A shadow model in the bench predicts the victim way, the write-back address and the write-back contents for every miss.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT
  } miss_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
  import wbc_pkg::*;
#(
  parameter int SETS  = 1024,
  parameter int TAG_W = 19,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           idx,
  input  logic [TAG_W-1:0]           cmp_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic [WAYS-1:0]            vld_vec,
  output logic [WAYS-1:0]            dirty_vec,
  output logic [WAYS-1:0][TAG_W-1:0] tag_vec,
  output logic                       lru_way,
  input  logic                       fill_en,
  input  logic                       fill_way,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic                       dirty_en,
  input  logic                       dirty_way,
  input  logic                       touch_en,
  input  logic                       touch_way
);
  logic [SETS-1:0] lru_q;

  // recency: the bit names the way to replace next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q <= '0;
    else if (touch_en) lru_q[idx] <= ~touch_way;
  end
  assign lru_way = lru_q[idx];

  AST_LRU_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_q[$past(idx)] != $past(touch_way))); // R5

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic ME = (w == 1);
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q   <= '0;
        dirty_q <= '0;
      end else if (fill_en && fill_way == ME) begin
        vld_q[idx]   <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (dirty_en && dirty_way == ME) begin
        dirty_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == ME) tag_q[idx] <= fill_tag;
    end

    assign vld_vec[w]   = vld_q[idx];
    assign dirty_vec[w] = dirty_q[idx];
    assign tag_vec[w]   = tag_q[idx];
    assign hit_vec[w]   = vld_q[idx] && (tag_q[idx] == cmp_tag);

    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_way == ME) |=> (vld_q[$past(idx)] && !dirty_q[$past(idx)])); // R8
    AST_STORE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_en && dirty_way == ME && !fill_en) |=> dirty_q[$past(idx)]); // R4
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store
  import wbc_pkg::*;
#(
  parameter int SETS       = 1024,
  parameter int LINE_BYTES = 8,
  parameter int IDX_W      = $clog2(SETS),
  parameter int DATA_W     = 8 * LINE_BYTES
) (
  input  logic                        clk,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        wr_en,
  input  logic                        wr_way,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [LINE_BYTES-1:0]       wr_be,
  output logic [WAYS-1:0][DATA_W-1:0] rd_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic ME = (w == 1);
    logic [DATA_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == ME) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (wr_be[b]) line_q[idx][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end

    assign rd_vec[w] = line_q[idx];
  end
endmodule

// File: rtl/wbc_miss_fsm.sv
module wbc_miss_fsm
  import wbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss,
  input  logic        vict_way,
  input  logic        vict_dirty,
  input  logic        mem_done,
  output miss_state_e state,
  output logic        mem_req,
  output logic        mem_we,
  output logic        fill_en,
  output logic        vway
);
  miss_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vway    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss) begin
          vway    <= vict_way;
          state_q <= vict_dirty ? ST_WB_REQ : ST_RD_REQ;
        end
        ST_WB_REQ:  state_q <= ST_WB_WAIT;
        ST_WB_WAIT: if (mem_done) state_q <= ST_RD_REQ;
        ST_RD_REQ:  state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_done) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign state   = state_q;
  assign mem_req = (state_q == ST_WB_REQ) || (state_q == ST_RD_REQ);
  assign mem_we  = (state_q == ST_WB_REQ);
  assign fill_en = (state_q == ST_RD_WAIT) && mem_done;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R9
  AST_WB_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_REQ && $past(state_q) == ST_WB_WAIT) |-> $past(mem_done)); // R6
  AST_READ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB_WAIT && mem_done) |=> (mem_req && !mem_we)); // R6
endmodule

// File: rtl/wb2way_cache.sv
module wb2way_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 1024,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [8*LINE_BYTES-1:0] req_wdata,
  input  logic [LINE_BYTES-1:0]   req_be,
  output logic [8*LINE_BYTES-1:0] rsp_rdata,
  output logic                    stall,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*LINE_BYTES-1:0] mem_wdata,
  input  logic                    mem_done,
  input  logic [8*LINE_BYTES-1:0] mem_rdata
);
  localparam int DATA_W = 8 * LINE_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_line_addr(input logic [TAG_W-1:0] t,
                                                    input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  logic [IDX_W-1:0]            idx;
  logic [TAG_W-1:0]            tag;
  logic [WAYS-1:0]             hit_vec, vld_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0]  tag_vec;
  logic [WAYS-1:0][DATA_W-1:0] data_vec;
  logic                        lru_way, hit_any, hit_way;
  logic                        vict_sel, vict_dirty, vway, fill_en, miss;
  logic                        hit_done, store_hit, touch_en, touch_way;
  logic                        wr_en, wr_way;
  logic [DATA_W-1:0]           wr_data;
  logic [LINE_BYTES-1:0]       wr_be;
  miss_state_e                 state;

  assign idx     = f_index(req_addr);
  assign tag     = f_tag(req_addr);
  assign hit_any = |hit_vec;
  assign hit_way = hit_vec[1];

  // named events used by the checks
  assign hit_done  = (state == ST_IDLE) && req_valid && hit_any;
  assign miss      = (state == ST_IDLE) && req_valid && !hit_any;
  assign store_hit = hit_done && req_write;

  // victim: first invalid way, otherwise the least recent one
  assign vict_sel   = !vld_vec[0] ? 1'b0 : (!vld_vec[1] ? 1'b1 : lru_way);
  assign vict_dirty = vld_vec[vict_sel] && dirty_vec[vict_sel];

  assign touch_en  = hit_done || fill_en;
  assign touch_way = fill_en ? vway : hit_way;

  assign wr_en   = fill_en || store_hit;
  assign wr_way  = fill_en ? vway : hit_way;
  assign wr_data = fill_en ? mem_rdata : req_wdata;
  assign wr_be   = fill_en ? {LINE_BYTES{1'b1}} : req_be;

  wbc_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk, .rst_n, .idx, .cmp_tag(tag),
    .hit_vec, .vld_vec, .dirty_vec, .tag_vec, .lru_way,
    .fill_en, .fill_way(vway), .fill_tag(tag),
    .dirty_en(store_hit), .dirty_way(hit_way),
    .touch_en, .touch_way
  );

  wbc_data_store #(.SETS(SETS), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)) u_data (
    .clk, .idx, .wr_en, .wr_way, .wr_data, .wr_be, .rd_vec(data_vec)
  );

  wbc_miss_fsm u_fsm (
    .clk, .rst_n, .miss, .vict_way(vict_sel), .vict_dirty, .mem_done,
    .state, .mem_req, .mem_we, .fill_en, .vway
  );

  assign rsp_rdata = data_vec[hit_way];
  assign stall     = (state != ST_IDLE) || (req_valid && !hit_any);
  assign mem_addr  = mem_we ? f_line_addr(tag_vec[vway], idx) : f_line_addr(tag, idx);
  assign mem_wdata = data_vec[vway];

  AST_MEM_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> stall); // R10
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_done |-> !mem_req); // R3
  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (vld_vec[vway] && dirty_vec[vway])); // R7
  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (state != ST_IDLE)); // R10
endmodule

// File: tb/wb2way_cache_bench.sv
module wb2way_cache_bench;
  localparam int AW = 16;
  localparam int NSETS = 4;
  localparam int NLINES = 1 << (AW - 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0] req_be = '0;
  logic [63:0] rsp_rdata, mem_wdata;
  logic stall, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic mem_done = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  wb2way_cache #(.ADDR_W(AW), .SETS(NSETS), .LINE_BYTES(8)) u_wb2way_cache (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_be,
    .rsp_rdata, .stall, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_done, .mem_rdata
  );

  int total = 0, bad = 0;

  function automatic logic [63:0] pat(input int line);
    logic [15:0] l = 16'(line);
    return {l ^ 16'hA5C3, 16'(l * 7), ~l, l + 16'h1234};
  endfunction

  // backing memory with varying latency
  logic [63:0] bmem [NLINES];
  logic pend = 1'b0, m_we = 1'b0;
  int cnt = 0, opn = 0, wb_cnt = 0, rd_cnt = 0, mon_bad = 0;
  int m_line = 0;
  logic [63:0] m_wd = '0;
  logic [AW-1:0] last_wb_addr = '0;
  logic [63:0] last_wb_data = '0;

  always @(posedge clk) begin
    mem_done <= 1'b0;
    if (mem_req) begin
      if (pend) mon_bad <= mon_bad + 1;
      pend   <= 1'b1;
      cnt    <= opn % 3;
      opn    <= opn + 1;
      m_we   <= mem_we;
      m_line <= int'(mem_addr >> 3);
      m_wd   <= mem_wdata;
      if (mem_addr[2:0] != 3'b000) mon_bad <= mon_bad + 1;
      if (mem_we) begin
        wb_cnt <= wb_cnt + 1;
        last_wb_addr <= mem_addr;
        last_wb_data <= mem_wdata;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end else if (pend) begin
      if (cnt == 0) begin
        mem_done  <= 1'b1;
        mem_rdata <= bmem[m_line];
        if (m_we) bmem[m_line] <= m_wd;
        pend <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  // R9: back-to-back request cycles are a protocol failure
  logic prev_req = 1'b0;
  always @(posedge clk) begin
    if (rst_n && mem_req && prev_req) mon_bad <= mon_bad + 1;
    prev_req <= mem_req;
  end

  // shadow model
  logic [63:0] arch [NLINES];
  bit rv [NSETS][2];
  bit rdy [NSETS][2];
  int rtag [NSETS][2];
  int rlru [NSETS];

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int line, input logic [7:0] be,
                        input logic [63:0] wd, input string hit_rq);
    int s = line % NSETS;
    int tg = line / NSETS;
    int hw = -1, vw = 0, evl = 0, wb0, rd0, n;
    bit ewb = 0;
    logic [63:0] got;
    for (int w = 0; w < 2; w++) if (rv[s][w] && rtag[s][w] == tg) hw = w;
    if (hw < 0) begin
      vw  = !rv[s][0] ? 0 : (!rv[s][1] ? 1 : rlru[s]);
      ewb = rv[s][vw] && rdy[s][vw];
      evl = rtag[s][vw] * NSETS + s;
    end
    wb0 = wb_cnt;
    rd0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'((line << 3) | (line % 8));
    req_wdata = wd;
    req_be    = be;
    #1;
    n = 0;
    while (stall && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    got = rsp_rdata;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (hw >= 0) begin
      chk(n == 0, hit_rq, 64'(n), 64'd0);
      chk(wb_cnt == wb0 && rd_cnt == rd0, wr ? "R4" : "R3",
          64'(wb_cnt - wb0 + rd_cnt - rd0), 64'd0);
    end else begin
      chk(n > 0, "R10", 64'(n), 64'd1);
      chk(rd_cnt - rd0 == 1, wr ? "R8" : "R7", 64'(rd_cnt - rd0), 64'd1);
      chk(wb_cnt - wb0 == int'(ewb), ewb ? "R6" : "R7",
          64'(wb_cnt - wb0), 64'(ewb));
      if (ewb) begin
        chk(last_wb_addr == AW'(evl << 3), "R6", 64'(last_wb_addr), 64'(evl << 3));
        chk(last_wb_data == arch[evl], "R6", last_wb_data, arch[evl]);
      end
      rv[s][vw] = 1;
      rdy[s][vw] = 0;
      rtag[s][vw] = tg;
      hw = vw;
    end
    if (!wr) chk(got == arch[line], "R2", got, arch[line]);
    rlru[s] = 1 - hw;
    if (wr) begin
      for (int b = 0; b < 8; b++) if (be[b]) arch[line][8*b +: 8] = wd[8*b +: 8];
      rdy[s][hw] = 1;
    end
  endtask

  bit finished = 0;

  initial begin
    for (int l = 0; l < NLINES; l++) begin
      bmem[l] = pat(l);
      arch[l] = pat(l);
    end
    for (int s = 0; s < NSETS; s++) begin
      rlru[s] = 0;
      for (int w = 0; w < 2; w++) begin
        rv[s][w] = 0;
        rdy[s][w] = 0;
        rtag[s][w] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(stall == 1'b0, "R1", 64'(stall), 64'd0);
    chk(mem_req == 1'b0, "R1", 64'(mem_req), 64'd0);

    // fill both ways of every set, then re-hit (R1 first miss, R3 hits)
    for (int s = 0; s < NSETS; s++) begin
      access(0, s, 8'h00, '0, "R1");
      access(0, s + 4, 8'h00, '0, "R1");
      access(0, s, 8'h00, '0, "R3");
      access(0, s + 4, 8'h00, '0, "R3");
    end
    // partial stores into both ways (R4)
    for (int s = 0; s < NSETS; s++) begin
      access(1, s, 8'h0F, 64'h1111_2222_3333_4444 + 64'(s), "R4");
      access(1, s + 4, 8'hA5, 64'hDEAD_BEEF_0BAD_F00D ^ 64'(s), "R4");
      access(0, s, 8'h00, '0, "R4");
      access(0, s + 4, 8'h00, '0, "R4");
    end
    // both ways dirty: recency picks the victim (R5, R6)
    for (int s = 0; s < NSETS; s++) begin
      access(0, s, 8'h00, '0, "R5");
      access(0, s + 8, 8'h00, '0, "R5");
      access(0, s, 8'h00, '0, "R5");
      access(0, s + 4, 8'h00, '0, "R5");
    end
    // store misses allocate (R8)
    for (int s = 0; s < NSETS; s++) begin
      access(1, s + 12, 8'hF0, 64'hCAFE_0000_0000_0000 | 64'(s), "R8");
      access(0, s + 12, 8'h00, '0, "R8");
    end
    // pseudo-random mix over six tags per set
    begin
      logic [31:0] lcg = 32'h1234_5678;
      for (int k = 0; k < 400; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        access(lcg[31], int'(lcg[20:18] % 6) * NSETS + int'(lcg[17:16]),
               lcg[15:8], {lcg, ~lcg}, "R3");
      end
    end
    repeat (4) @(negedge clk);
    chk(mon_bad == 0, "R9", 64'(mon_bad), 64'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule